// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns four asynchronous external interrupt pins into pending flags that an interrupt arbiter can consume. Every pin first passes through a two-stage synchronizer. After that, each pin is handled according to its channel class and configuration.

Channels 0 and 1 are active-low. Each can run in one of two modes:
- **Level mode:** the flag is the inverted synchronized pin.
- **Edge mode:** a falling edge latches the flag. The flag clears when the processor acknowledges the vector, or when software clears it.

Channels 2 and 3 are edge-only, and each channel's edge polarity is selectable. Their flags stay set until software clears them.

Two 8-bit register views expose the flags and configuration. The control view covers channels 0/1 and the alternate view covers channels 2/3. Writing 0 to a flag bit clears it. Writing 1 to a flag bit does nothing. The combined flags also appear on `pend_o` for the arbiter.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, both channel 0/1 modes are 0 (level), both channel 2/3 edge selects are 0 (falling), all latched flags are 0, and `pend_o`, `ctl_rdata_o` and `alt_rdata_o` read 0 while the pins are high.
- R2: With its mode bit at 0, the flag of channel 0 or 1 equals the inverse of the synchronized pin. Acknowledges and flag-clear writes have no effect on it.
- R3: With its mode bit at 1, the flag of channel 0 or 1 is set by a falling edge on the synchronized pin. It is cleared by `ack_i[n]`, or by a control write with a 0 in its flag bit. Writing a 1 to the flag bit leaves the flag unchanged.
- R4: The flag of channel 2 or 3 is set by the edge chosen by its select bit, where 0 selects falling and 1 selects rising. Edges of the other polarity are ignored.
- R5: A channel 2 or 3 flag stays set until an alternate-view write puts a 0 in its flag bit (bit 6 for channel 2, bit 7 for channel 3). `ack_i` does not affect it.
- R6: Each pin passes through two synchronizer flops. A level-mode flag changes two clock edges after the pin changes. An edge flag is set on the third edge after the pin changes.
- R7: The control view holds the modes at bits 1:0 and the channel 0/1 flags at bits 5:4. The alternate view holds the flags at bits 7:6 and the edge selects at bits 3:2. All other bits read 0, and writes to them are ignored.
- R8: When a flag's hardware set and its clear (software or acknowledge) occur in the same cycle, the flag ends up set.
- R9: Changing a mode or edge-select bit never produces an edge. Edges are detected only between two successive synchronized samples, and never from the reset value of the synchronizer.
- R10: Switching channel 0 or 1 from edge mode to level mode discards its latched flag. The flag does not reappear on a later return to edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | Raw external interrupt pins; [1:0] active-low, [3:2] edge-only |
| ack_i | input | 2 | Vector acknowledge for channels 0 and 1 |
| ctl_we_i | input | 1 | Control view write strobe |
| ctl_wdata_i | input | 8 | Control view write data |
| alt_we_i | input | 1 | Alternate view write strobe |
| alt_wdata_i | input | 8 | Alternate view write data |
| ctl_rdata_o | output | 8 | Control view read data |
| alt_rdata_o | output | 8 | Alternate view read data |
| pend_o | output | 4 | Pending flags for all four channels |

## Verification
The assertions check several properties on every cycle:
- In level mode, the flag tracks the synchronized pin.
- A detected edge always leaves the flag set, even against a simultaneous clear.
- An acknowledge clears an edge-mode flag.
- A channel 2/3 flag falls only after a clearing write.
- Unused bits stay zero and configuration bits read back what was written.

Some behaviours can only be shown by the bench's scenarios compared against its reference model:
- The exact synchronizer latency from pin to flag.
- That polarity and mode changes create no false edges.
- That a latched flag is dropped when its channel switches to level mode.
- The long random mix of pins, acknowledges and writes.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
  localparam int unsigned REG_W        = 8;
  localparam int unsigned NUM_ACT_LOW  = 2;  // channels 0..1: level or falling edge
  localparam int unsigned NUM_SEL_EDGE = 2;  // channels 2..3: selectable edge
  localparam int unsigned NUM_CH       = NUM_ACT_LOW + NUM_SEL_EDGE;
  localparam int unsigned CTL_MODE_LSB = 0;
  localparam int unsigned CTL_FLAG_LSB = 4;
  localparam int unsigned ALT_SEL_LSB  = 2;
  localparam int unsigned ALT_FLAG_LSB = 6;
endpackage

// File: rtl/ext_irq_sync.sv
`timescale 1ns/1ps
module ext_irq_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         valid_o
);
  localparam int unsigned CW = $clog2(STAGES + 1);

  logic [W-1:0]  stg_q [STAGES];
  logic [CW-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '1;
      fill_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
      if (fill_q != CW'(STAGES)) fill_q <= fill_q + 1'b1;
    end
  end

  assign q_o     = stg_q[STAGES-1];
  // output carries a real pin sample once the chain has filled
  assign valid_o = (fill_q == CW'(STAGES));
endmodule

// File: rtl/ext_irq_edge.sv
`timescale 1ns/1ps
module ext_irq_edge #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         valid_i,
  input  logic [W-1:0] rise_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;
  logic         prev_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '1;
      prev_ok_q <= 1'b0;
    end else begin
      prev_q    <= lvl_i;
      prev_ok_q <= valid_i;
    end
  end

  // polarity only selects which sample pair counts; no edge from a select change
  for (genvar g = 0; g < int'(W); g++) begin : g_det
    assign evt_o[g] = prev_ok_q & valid_i &
                      (rise_i[g] ? (~prev_q[g] & lvl_i[g]) : (prev_q[g] & ~lvl_i[g]));
  end
endmodule

// File: rtl/ext_irq_flag.sv
`timescale 1ns/1ps
module ext_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_zero_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_o <= 1'b0;
    else if (hold_zero_i) q_o <= 1'b0;
    else if (set_i)       q_o <= 1'b1;  // set beats clear
    else if (clr_i)       q_o <= 1'b0;
  end
endmodule

// File: rtl/ext_irq_cond.sv
`timescale 1ns/1ps
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [NUM_ACT_LOW-1:0] ack_i,
  input  logic             ctl_we_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  input  logic             alt_we_i,
  input  logic [REG_W-1:0] alt_wdata_i,
  output logic [REG_W-1:0] ctl_rdata_o,
  output logic [REG_W-1:0] alt_rdata_o,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0]       sync_lvl;
  logic                    sync_vld;
  logic [NUM_CH-1:0]       edge_evt;
  logic [NUM_CH-1:0]       rise_sel;
  logic [NUM_CH-1:0]       latch_q;
  logic [NUM_CH-1:0]       flag_clr;
  logic [NUM_CH-1:0]       flag_hold0;
  logic [NUM_ACT_LOW-1:0]  mode_q;
  logic [NUM_SEL_EDGE-1:0] sel_q;

  ext_irq_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync_lvl), .valid_o(sync_vld)
  );

  assign rise_sel = {sel_q, {NUM_ACT_LOW{1'b0}}};

  ext_irq_edge #(.W(NUM_CH)) u_edge (
    .clk_i, .rst_ni, .lvl_i(sync_lvl), .valid_i(sync_vld),
    .rise_i(rise_sel), .evt_o(edge_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      sel_q  <= '0;
    end else begin
      if (ctl_we_i) mode_q <= ctl_wdata_i[CTL_MODE_LSB +: NUM_ACT_LOW];
      if (alt_we_i) sel_q  <= alt_wdata_i[ALT_SEL_LSB +: NUM_SEL_EDGE];
    end
  end

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
    if (g < int'(NUM_ACT_LOW)) begin : g_al
      assign flag_clr[g]   = (ctl_we_i & ~ctl_wdata_i[CTL_FLAG_LSB + g]) | ack_i[g];
      assign flag_hold0[g] = ~mode_q[g];
      assign pend_o[g]     = mode_q[g] ? latch_q[g] : ~sync_lvl[g];
    end else begin : g_se
      assign flag_clr[g]   = alt_we_i & ~alt_wdata_i[ALT_FLAG_LSB + g - NUM_ACT_LOW];
      assign flag_hold0[g] = 1'b0;
      assign pend_o[g]     = latch_q[g];
    end
    ext_irq_flag u_flag (
      .clk_i, .rst_ni, .set_i(edge_evt[g]), .clr_i(flag_clr[g]),
      .hold_zero_i(flag_hold0[g]), .q_o(latch_q[g])
    );
  end

  always_comb begin
    ctl_rdata_o = '0;
    ctl_rdata_o[CTL_MODE_LSB +: NUM_ACT_LOW] = mode_q;
    ctl_rdata_o[CTL_FLAG_LSB +: NUM_ACT_LOW] = pend_o[NUM_ACT_LOW-1:0];
    alt_rdata_o = '0;
    alt_rdata_o[ALT_SEL_LSB +: NUM_SEL_EDGE]  = sel_q;
    alt_rdata_o[ALT_FLAG_LSB +: NUM_SEL_EDGE] = pend_o[NUM_CH-1:NUM_ACT_LOW];
  end
endmodule

// File: rtl/ext_irq_cond_chk.sv
`timescale 1ns/1ps
module ext_irq_cond_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] lvl_i,
  input logic [3:0] evt_i,
  input logic [1:0] mode_i,
  input logic [1:0] ack_i,
  input logic       ctl_we_i,
  input logic [7:0] ctl_wdata_i,
  input logic       alt_we_i,
  input logic [7:0] alt_wdata_i,
  input logic [7:0] ctl_rdata_o,
  input logic [7:0] alt_rdata_o,
  input logic [3:0] pend_o
);
  assert_level_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[0] |-> pend_o[0] == !lvl_i[0]);

  assert_ack_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && ack_i[1] && !evt_i[1] && !ctl_we_i) |=> !pend_o[1]);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[0] && evt_i[0] && !ctl_we_i) |=> pend_o[0]);

  assert_sel_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[2] |=> pend_o[2]);

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_o[3]) |-> $past(alt_we_i && !alt_wdata_i[7]));

  assert_unused_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o & 8'hCC) == 8'h00 && (alt_rdata_o & 8'h33) == 8'h00);

  assert_ctl_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> ((ctl_rdata_o ^ $past(ctl_wdata_i)) & 8'h03) == 8'h00);

  assert_alt_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_we_i |=> ((alt_rdata_o ^ $past(alt_wdata_i)) & 8'h0C) == 8'h00);
endmodule

bind ext_irq_cond ext_irq_cond_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_lvl), .evt_i(edge_evt),
  .mode_i(mode_q), .ack_i(ack_i), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
  .alt_we_i(alt_we_i), .alt_wdata_i(alt_wdata_i), .ctl_rdata_o(ctl_rdata_o),
  .alt_rdata_o(alt_rdata_o), .pend_o(pend_o)
);

// File: tb/tb_ext_irq_cond.sv
`timescale 1ns/1ps
module tb_ext_irq_cond;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pin_i = 4'hF;
  logic [1:0] ack_i = '0;
  logic       ctl_we_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0;
  logic       alt_we_i = 1'b0;
  logic [7:0] alt_wdata_i = '0;
  logic [7:0] ctl_rdata_o, alt_rdata_o;
  logic [3:0] pend_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string phase = "R1 reset";

  always #4 clk_i = ~clk_i;  // 125 MHz

  ext_irq_cond dut (.*);

  // behavioural reference: history of sampled pins, indexed by edge number
  logic [3:0] hist[$];
  int         k;
  logic [1:0] m_mode, m_sel;
  logic [3:0] m_latch, m_s2;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist.delete(); k = 0; m_mode = '0; m_sel = '0; m_latch = '0; m_s2 = 4'hF;
    end else begin
      logic [3:0] evt, clr;
      k++;
      evt = '0;
      if (k >= 4) begin
        for (int c = 0; c < 4; c++) begin
          bit nw, od, rise;
          nw = hist[k-3][c]; od = hist[k-4][c];
          rise = (c >= 2) ? m_sel[c-2] : 1'b0;
          evt[c] = rise ? (!od && nw) : (od && !nw);
        end
      end
      clr[0] = (ctl_we_i && !ctl_wdata_i[4]) || ack_i[0];
      clr[1] = (ctl_we_i && !ctl_wdata_i[5]) || ack_i[1];
      clr[2] = alt_we_i && !alt_wdata_i[6];
      clr[3] = alt_we_i && !alt_wdata_i[7];
      for (int c = 0; c < 4; c++) begin
        if (c < 2 && !m_mode[c]) m_latch[c] = 1'b0;
        else if (evt[c])         m_latch[c] = 1'b1;
        else if (clr[c])         m_latch[c] = 1'b0;
      end
      if (ctl_we_i) m_mode = ctl_wdata_i[1:0];
      if (alt_we_i) m_sel  = alt_wdata_i[3:2];
      hist.push_back(pin_i);
      m_s2 = (k >= 2) ? hist[k-2] : 4'hF;
    end
  end

  function automatic logic [3:0] exp_pend();
    logic [3:0] p;
    for (int c = 0; c < 4; c++)
      p[c] = (c < 2 && !m_mode[c]) ? !m_s2[c] : m_latch[c];
    return p;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] got %h exp %h at %0t", req, phase, got, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [3:0] ep;
      ep = exp_pend();
      chk(m_mode[0] ? "R3 ch0" : "R2 ch0", {7'd0, pend_o[0]}, {7'd0, ep[0]});
      chk(m_mode[1] ? "R3 ch1" : "R2 ch1", {7'd0, pend_o[1]}, {7'd0, ep[1]});
      chk("R4 ch2/ch3", {6'd0, pend_o[3:2]}, {6'd0, ep[3:2]});
      chk("R7 ctl view", ctl_rdata_o, {2'b00, ep[1:0], 2'b00, m_mode});
      chk("R7 alt view", alt_rdata_o, {ep[3:2], 2'b00, m_sel, 2'b00});
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk_i); #2; end
  endtask
  task automatic wr_ctl(logic [7:0] d);
    ctl_we_i = 1'b1; ctl_wdata_i = d; step(); ctl_we_i = 1'b0;
  endtask
  task automatic wr_alt(logic [7:0] d);
    alt_we_i = 1'b1; alt_wdata_i = d; step(); alt_we_i = 1'b0;
  endtask

  initial begin
    #100000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    step(3);
    @(negedge clk_i);
    chk("R1 pend in reset", {4'd0, pend_o}, 8'h00);
    chk("R1 ctl in reset", ctl_rdata_o, 8'h00);
    chk("R1 alt in reset", alt_rdata_o, 8'h00);
    @(posedge clk_i); #2; rst_ni = 1'b1;
    step(6);

    phase = "R6 latency";
    pin_i[0] = 1'b0;
    @(negedge clk_i); @(posedge clk_i); @(negedge clk_i);
    chk("R6 one edge", {7'd0, pend_o[0]}, 8'h00);
    @(posedge clk_i); @(negedge clk_i);
    chk("R6 two edges", {7'd0, pend_o[0]}, 8'h01);
    #2;
    phase = "R2 level ignores clear";
    ack_i = 2'b11; wr_ctl(8'h00); ack_i = 2'b00; step(2);
    pin_i[0] = 1'b1; pin_i[1] = 1'b0; step(4); pin_i[1] = 1'b1; step(4);

    phase = "R3 edge mode";
    wr_ctl(8'h33);
    pin_i[0] = 1'b0; step(5);
    wr_ctl(8'h33); step(2);            // writing 1 to flag: no effect
    ack_i[0] = 1'b1; step(); ack_i[0] = 1'b0; step(2);
    pin_i[0] = 1'b1; step(3);
    pin_i[1] = 1'b0; step(5);
    wr_ctl(8'h03); step(2);            // software clear channel 1
    pin_i[1] = 1'b1; step(3);

    phase = "R8 set against ack";
    ack_i = 2'b11; pin_i[1:0] = 2'b00; step(6); ack_i = 2'b00; step(2);
    pin_i[1:0] = 2'b11; step(3);
    phase = "R8 set against write";
    pin_i[0] = 1'b0; step(2);
    wr_ctl(8'h03); step(3);            // edge event coincides with clearing write
    pin_i[0] = 1'b1; step(3);

    phase = "R10 mode drop";
    pin_i[1] = 1'b0; step(5);
    wr_ctl(8'h01); step(3);
    wr_ctl(8'h03); step(3);
    pin_i[1] = 1'b1; step(3);

    phase = "R4 selectable edges";
    wr_alt(8'h04);                     // ch2 rising, ch3 falling
    pin_i[3:2] = 2'b00; step(5);
    pin_i[3:2] = 2'b11; step(5);
    phase = "R5 sticky";
    ack_i = 2'b11; step(3); ack_i = 2'b00;
    wr_alt(8'hC4); step(2);
    wr_alt(8'h84); step(2);
    wr_alt(8'h04); step(2);

    phase = "R9 select change";
    wr_alt(8'h0C); step(3); wr_alt(8'h00); step(3);
    pin_i[3:2] = 2'b00; step(4);
    wr_alt(8'h0C); step(3); wr_alt(8'h00); step(3);
    wr_ctl(8'h00); pin_i[0] = 1'b0; step(4); wr_ctl(8'h03); step(4);
    pin_i = 4'hF; step(4);

    phase = "R7 unused bits";
    wr_ctl(8'hCC); step(2); wr_alt(8'h33); step(2); wr_ctl(8'hFF); step(2);

    phase = "R9 reset mid-low";
    pin_i = 4'h0; rst_ni = 1'b0; step(2); rst_ni = 1'b1;
    wr_alt(8'h00); wr_ctl(8'h03); step(6);

    phase = "R3 R4 R8 random";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) pin_i = lfsr[7:4];
      ack_i = (lfsr[11:9] == 3'd1) ? lfsr[13:12] : 2'b00;
      ctl_we_i = (lfsr[15:12] == 4'd3); ctl_wdata_i = lfsr[10:3];
      alt_we_i = (lfsr[15:12] == 4'd5); alt_wdata_i = lfsr[8:1];
      step();
    end
    ctl_we_i = 1'b0; alt_we_i = 1'b0; ack_i = '0;
    step(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule